// File: doc/BRIEF.md
# Configurable quasi-bidirectional port controller

This block is the control logic behind one 8-bit general-purpose I/O port. It keeps an output latch and two configuration registers. Together, the two configuration registers give every pin its own output mode. From these registers the block drives three abstract pad controls per pin: strong pull-up enable, weak pull-up enable and pull-down enable. A pin can also be handed to an alternate function. The alternate output then gates the level that the latch would drive. Reads return the pad level after synchronisation, not the latch contents.

Software can write the latch as a whole byte or one bit at a time. In quasi-bidirectional mode a pin whose latch goes from 0 to 1 gets a strong pull-up for one clock. After that, a weak pull-up holds the line high. Pins marked as bus pins (bits 6 and 7 by default) can never enable any pull-up. On those pins the quasi-bidirectional and push-pull modes fall back to open-drain behaviour.

Top module: `qb_port_ctrl`

## Requirements
- R1: After reset every latch bit is 1 and both configuration registers are 0 (all pins open-drain). All three control outputs are 0, pin_rd is 0, and no strong pull-up pulse follows the release of reset.
- R2: A byte write (lat_wr) loads the whole latch from lat_wdata. A bit write (bit_wr) loads bit bit_sel from bit_val. When both happen in one cycle, the bit write wins on its own bit.
- R3: Pin n takes its mode from {cfga[n], cfgb[n]}: 00 open-drain, 01 quasi-bidirectional, 10 high-impedance input, 11 push-pull. Pins may use different modes at the same time.
- R4: In open-drain mode pd_en is 1 exactly when the driven value is 0, and no pull-up is enabled.
- R5: In quasi-bidirectional mode, pd_en is 1 when the driven value is 0 and pu_weak is 1 while it is 1. When the latch goes from 0 to 1 and the driven value is 1, pu_strong is 1 for exactly one clock.
- R6: In push-pull mode, pu_strong stays 1 for as long as the driven value is 1, and pd_en is 1 while it is 0. pu_weak stays 0.
- R7: In high-impedance mode all three controls of the pin are 0.
- R8: With alt_en[n] set, the driven value of pin n is latch[n] AND alt_out[n]. Otherwise it is latch[n].
- R9: Bus pins (BUS_PINS, default bits 6 and 7) never enable pu_strong or pu_weak. In modes 01 and 11 they act as open-drain.
- R10: No pin ever has a pull-up and pd_en enabled in the same cycle.
- R11: pin_rd returns pad_in through a two-flop synchroniser. A pad change sampled at one clock edge shows up on pin_rd after the following edge.
- R12: All control outputs are registered. They reflect the register writes and the alt inputs that are sampled at a clock edge, starting right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_wr | input | 1 | Byte write strobe for the latch |
| lat_wdata | input | 8 | Byte write data for the latch |
| bit_wr | input | 1 | Single-bit write strobe for the latch |
| bit_sel | input | 3 | Latch bit selected by the bit write |
| bit_val | input | 1 | Value for the selected latch bit |
| cfga_wr | input | 1 | Write strobe, configuration register A |
| cfga_wdata | input | 8 | Write data, configuration register A |
| cfgb_wr | input | 1 | Write strobe, configuration register B |
| cfgb_wdata | input | 8 | Write data, configuration register B |
| alt_en | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Per-pin alternate-function output value |
| pad_in | input | 8 | Raw pad input levels |
| pu_strong | output | 8 | Strong pull-up enable per pin |
| pu_weak | output | 8 | Weak pull-up enable per pin |
| pd_en | output | 8 | Pull-down enable per pin |
| pin_rd | output | 8 | Synchronised pad levels for reads |

## Verification
Some properties are checked on every cycle by the assertions. No pin may pull up and down at once. Bus pins may never pull up. A pin configured as high-impedance must be completely quiet. The strong pull-up of a quasi-bidirectional pin must never last two cycles in a row. The rest can only be shown by the bench's scenarios, with a reference model compared on every clock. These behaviours are the exact cycle of the strong pulse after a 0-to-1 latch change, and the precedence of a bit write over a byte write. They also include alternate-function gating, the continuous pull-up in push-pull mode and the two-cycle delay of the read path.

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl #(
  parameter int W = 8,
  parameter logic [W-1:0] BUS_PINS = 8'hC0,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_wr,
  input  logic [W-1:0]  lat_wdata,
  input  logic          bit_wr,
  input  logic [SW-1:0] bit_sel,
  input  logic          bit_val,
  input  logic          cfga_wr,
  input  logic [W-1:0]  cfga_wdata,
  input  logic          cfgb_wr,
  input  logic [W-1:0]  cfgb_wdata,
  input  logic [W-1:0]  alt_en,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pu_strong,
  output logic [W-1:0]  pu_weak,
  output logic [W-1:0]  pd_en,
  output logic [W-1:0]  pin_rd
);

  logic [W-1:0] lat_q, ca_q, cb_q;
  logic [W-1:0] lat_n, ca_n, cb_n;
  logic [W-1:0] drv, rise, od_n, qb_n, pp_n;
  logic [W-1:0] s_n, w_n, d_n;
  logic [W-1:0] sync1;

  always_comb begin
    lat_n = lat_wr ? lat_wdata : lat_q;
    if (bit_wr) lat_n[bit_sel] = bit_val;
  end

  assign ca_n = cfga_wr ? cfga_wdata : ca_q;
  assign cb_n = cfgb_wr ? cfgb_wdata : cb_q;

  assign drv  = lat_n & (~alt_en | alt_out);
  assign rise = lat_n & ~lat_q;

  assign od_n = ~ca_n & ~cb_n;
  assign qb_n = ~ca_n &  cb_n;
  assign pp_n =  ca_n &  cb_n;

  assign d_n = (od_n | qb_n | pp_n) & ~drv;
  assign w_n = qb_n & drv & ~BUS_PINS;
  assign s_n = ((qb_n & rise) | pp_n) & drv & ~BUS_PINS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= '1;
      ca_q      <= '0;
      cb_q      <= '0;
      pu_strong <= '0;
      pu_weak   <= '0;
      pd_en     <= '0;
      sync1     <= '0;
      pin_rd    <= '0;
    end else begin
      lat_q     <= lat_n;
      ca_q      <= ca_n;
      cb_q      <= cb_n;
      pu_strong <= s_n;
      pu_weak   <= w_n;
      pd_en     <= d_n;
      sync1     <= pad_in;
      pin_rd    <= sync1;
    end
  end

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_strong | pu_weak) & pd_en) == '0);                        // R10

  AST_BUS_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_strong | pu_weak) & BUS_PINS) == '0);                     // R9

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_strong | pu_weak | pd_en) & ca_q & ~cb_q) == '0);         // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_strong & ~ca_q & cb_q & $past(pu_strong)) == '0);          // R5

endmodule

// File: tb/qb_port_ctrl_test.sv
`timescale 1ns/1ps
module qb_port_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic lat_wr = 0, bit_wr = 0, bit_val = 0, cfga_wr = 0, cfgb_wr = 0;
  logic [2:0] bit_sel = 0;
  logic [7:0] lat_wdata = 0, cfga_wdata = 0, cfgb_wdata = 0;
  logic [7:0] alt_en = 0, alt_out = 0, pad_in = 0;
  logic [7:0] pu_strong, pu_weak, pd_en, pin_rd;

  always #4 clk = ~clk;

  qb_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .lat_wr(lat_wr), .lat_wdata(lat_wdata),
    .bit_wr(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val),
    .cfga_wr(cfga_wr), .cfga_wdata(cfga_wdata),
    .cfgb_wr(cfgb_wr), .cfgb_wdata(cfgb_wdata),
    .alt_en(alt_en), .alt_out(alt_out), .pad_in(pad_in),
    .pu_strong(pu_strong), .pu_weak(pu_weak), .pd_en(pd_en), .pin_rd(pin_rd)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  string phase = "R1";
  bit done = 0;

  bit m_lat[8], m_ca[8], m_cb[8];
  bit e_s[8], e_w[8], e_d[8];
  logic [7:0] rd_q[$];

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_lat[i] = 1; m_ca[i] = 0; m_cb[i] = 0; e_s[i] = 0; e_w[i] = 0; e_d[i] = 0;
    end
    rd_q = '{8'h00, 8'h00};
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_lat[i] = 1; m_ca[i] = 0; m_cb[i] = 0; e_s[i] = 0; e_w[i] = 0; e_d[i] = 0;
      end
      rd_q = '{8'h00, 8'h00};
    end else begin
      bit nl[8];
      rd_q.push_back(pad_in);
      void'(rd_q.pop_front());
      for (int i = 0; i < 8; i++) nl[i] = lat_wr ? lat_wdata[i] : m_lat[i];
      if (bit_wr) nl[bit_sel] = bit_val;
      for (int i = 0; i < 8; i++) begin
        if (cfga_wr) m_ca[i] = cfga_wdata[i];
        if (cfgb_wr) m_cb[i] = cfgb_wdata[i];
      end
      for (int i = 0; i < 8; i++) begin
        bit v, up, bus;
        int mode;
        v = alt_en[i] ? (nl[i] & alt_out[i]) : nl[i];
        up = nl[i] && !m_lat[i];
        bus = (i >= 6);
        mode = m_ca[i] * 2 + m_cb[i];
        e_s[i] = 0; e_w[i] = 0; e_d[i] = 0;
        case (mode)
          0: e_d[i] = !v;
          1: begin e_d[i] = !v; e_w[i] = v && !bus; e_s[i] = up && v && !bus; end
          2: ;
          default: begin e_d[i] = !v; e_s[i] = v && !bus; end
        endcase
        m_lat[i] = nl[i];
      end
    end
  end

  function automatic string pin_tag(int i);
    int mode;
    if (i >= 6) return "R9";
    if (alt_en[i]) return "R8";
    mode = m_ca[i] * 2 + m_cb[i];
    case (mode)
      0: return "R4";
      1: return "R5";
      2: return "R7";
      default: return "R6";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      bit bad = 0;
      vectors++;
      for (int i = 0; i < 8; i++) begin
        if (pu_strong[i] !== e_s[i] || pu_weak[i] !== e_w[i] || pd_en[i] !== e_d[i]) begin
          bad = 1;
          $display("FAIL %s/%s pin %0d: s/w/d actual %b%b%b expected %b%b%b", phase, pin_tag(i), i,
                   pu_strong[i], pu_weak[i], pd_en[i], e_s[i], e_w[i], e_d[i]);
        end
        if ((pu_strong[i] | pu_weak[i]) & pd_en[i]) begin
          bad = 1;
          $display("FAIL R10 pin %0d: pull-up and pull-down together actual 1 expected 0", i);
        end
      end
      if (pin_rd !== rd_q[0]) begin
        bad = 1;
        $display("FAIL R11 (%s): pin_rd actual %h expected %h", phase, pin_rd, rd_q[0]);
      end
      if (bad) miscompares++;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    lat_wr = 0; bit_wr = 0; cfga_wr = 0; cfgb_wr = 0;
  endtask

  task automatic wr_lat(logic [7:0] d);
    lat_wr = 1; lat_wdata = d; step(); idle();
  endtask

  task automatic wr_cfg(logic [7:0] a, logic [7:0] b);
    cfga_wr = 1; cfga_wdata = a; cfgb_wr = 1; cfgb_wdata = b; step(); idle();
  endtask

  initial begin
    phase = "R1";
    step(3);
    rst_n = 1;
    step(4);
    phase = "R3";
    wr_cfg(8'b1111_1000, 8'b1101_1010);
    foreach (lat_wdata[i]) ;
    wr_lat(8'h00); step(2);
    wr_lat(8'hFF); step(2);
    wr_lat(8'hAA); wr_lat(8'h55); wr_lat(8'hFF); step();
    phase = "R5";
    wr_cfg(8'h00, 8'hFF);
    wr_lat(8'h00); wr_lat(8'hFF); step(3);
    phase = "R2";
    bit_wr = 1; bit_sel = 3; bit_val = 0; step(); idle();
    bit_wr = 1; bit_sel = 3; bit_val = 1; step(); idle();
    lat_wr = 1; lat_wdata = 8'h00; bit_wr = 1; bit_sel = 5; bit_val = 1; step(); idle();
    lat_wr = 1; lat_wdata = 8'hFF; bit_wr = 1; bit_sel = 0; bit_val = 0; step(); idle();
    step(2);
    phase = "R6";
    wr_cfg(8'hFF, 8'hFF);
    wr_lat(8'h0F); wr_lat(8'hF0); step(3);
    phase = "R7";
    wr_cfg(8'hFF, 8'h00);
    wr_lat(8'h00); wr_lat(8'hFF); step(2);
    phase = "R8";
    wr_cfg(8'h00, 8'hFF);
    alt_en = 8'hFF; alt_out = 8'h3C; step(2);
    alt_out = 8'hC3; step(2);
    wr_lat(8'h00); alt_out = 8'hFF; wr_lat(8'hFF); step(2);
    alt_en = 8'h00;
    phase = "R11";
    pad_in = 8'hA5; step(); pad_in = 8'h5A; step(); pad_in = 8'hFF; step(3);
    phase = "R12";
    for (int k = 0; k < 4000; k++) begin
      lat_wr = $urandom_range(0, 3) == 0; lat_wdata = 8'($urandom);
      bit_wr = $urandom_range(0, 3) == 0; bit_sel = 3'($urandom); bit_val = 1'($urandom);
      cfga_wr = $urandom_range(0, 15) == 0; cfga_wdata = 8'($urandom);
      cfgb_wr = $urandom_range(0, 15) == 0; cfgb_wdata = 8'($urandom);
      alt_en = 8'($urandom); alt_out = 8'($urandom); pad_in = 8'($urandom);
      step();
    end
    idle(); alt_en = 0;
    phase = "R1";
    rst_n = 0; step(2); rst_n = 1; step(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog (%s): cycles actual %0d expected < 100000", phase, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule